// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

This block compares a 16-bit free-running count, supplied from outside, against five independent 16-bit compare values. When the count steps onto a channel's compare value and that channel is enabled, the block latches a per-channel flag. Software programs the compare values one byte at a time over a byte-wide register bus. It uses the same bus to set a per-channel enable mask and to read or clear the flags.

A single interrupt request is raised while any latched flag has its enable bit set. The count may advance once per clock or once every several clocks, for example behind a prescaler. A match is recognised only on the clock in which the count takes on a new value, so a count that is held for several clocks still produces a single event.

Top module: `ocu_top`

## Requirements
- R1: After reset every compare register reads 0xFFFF, the enable register and the flag register read 0x00, and the interrupt output is low.
- R2: Register offsets: offset 2k holds the high byte and offset 2k+1 the low byte of channel k+1's compare value (k = 0..4). Offset 10 is the enable register and offset 11 is the flag register. Bits 2..0 of the enable and flag registers read as zero. Offsets 12..15 read as zero, and writes to them change nothing.
- R3: Channel n (1..5) owns bit 8-n of the enable and flag registers, so channel 1 is bit 7 and channel 5 is bit 3. Its flag becomes set one clock after the count changes to a value equal to its compare value while its enable bit is set.
- R4: A channel whose enable bit is clear never gets its flag set. With all five enable bits clear, no flag is set.
- R5: A match is detected only in the clock where the count differs from its value one clock earlier. A count held at a matching value sets the flag once, and the flag stays clear after software clears it. No match is detected in the first clock after reset.
- R6: When several enabled channels match the same count, all of their flags are set in the same clock.
- R7: Writing the flag register clears each flag whose bit is written as one and leaves the bits written as zero unchanged. If a match sets a flag in the same clock that a write clears it, the flag ends up set.
- R8: The interrupt output is high exactly when some flag bit is set and the same enable bit is set. Clearing the enable bit drops the interrupt but keeps the flag.
- R9: A compare byte written in one clock is used for the match check from the next clock onward. A compare register keeps its value when it is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| count_i | input | 16 | Free-running count value |
| bus_addr_i | input | 4 | Register offset |
| bus_wr_i | input | 1 | Write strobe, one byte per clock |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined compare interrupt request |

## Verification
The assertions assume that the count input and the bus signals are stable and known at every rising edge. They also assume that a change in the count reflects a real step of the counter, not a glitch. The bench drives all inputs one time unit after a rising edge and holds them for the whole clock. It changes the count only through explicit steps, and it keeps the count held while compare bytes are written, so a write alone can never create a change event.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  typedef logic [3:0] ch_idx_t;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_CMP_HI,
    REG_CMP_LO,
    REG_ENABLE,
    REG_FLAG
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    ch_idx_t   ch;
  } reg_sel_t;

endpackage

// File: rtl/ocu_change_det.sv
module ocu_change_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  output logic             evt_o
);

  logic [CNT_W-1:0] prev_q;
  logic             primed_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= count_i;
      primed_q <= 1'b1;
    end
  end

  assign evt_o = primed_q && (count_i != prev_q);

  // R5: an event only ever reports a real step of the count
  p_evt_is_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (count_i != $past(count_i)));

endmodule

// File: rtl/ocu_channel.sv
module ocu_channel #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o
);

  localparam int HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] cmp_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cmp_q <= '1;
    end else begin
      if (wr_hi_i) cmp_q[CNT_W-1:BUS_W] <= wdata_i[HI_W-1:0];
      if (wr_lo_i) cmp_q[BUS_W-1:0]     <= wdata_i;
    end
  end

  assign cmp_o = cmp_q;
  assign hit_o = (cmp_q == count_i);

  // R2: a high-byte write lands in the upper half
  p_hi_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (cmp_q[CNT_W-1:BUS_W] == $past(wdata_i[HI_W-1:0])));

  // R2: a low-byte write lands in the lower half
  p_lo_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (cmp_q[BUS_W-1:0] == $past(wdata_i)));

  // R9: an unwritten compare register holds its value
  p_cmp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_hi_i || wr_lo_i) |=> $stable(cmp_q));

endmodule

// File: rtl/ocu_flags.sv
module ocu_flags #(
  parameter int NCH = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           evt_i,
  input  logic [NCH-1:0] hit_i,
  input  logic           en_wr_i,
  input  logic [NCH-1:0] en_wdata_i,
  input  logic           flag_wr_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] flag_o,
  output logic           irq_o
);

  logic [NCH-1:0] en_q;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] set_vec;
  logic [NCH-1:0] clr_vec;
  logic [NCH-1:0] flag_d;

  assign set_vec = evt_i ? (hit_i & en_q) : '0;
  assign clr_vec = flag_wr_i ? clr_i : '0;
  assign flag_d  = (flag_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_wr_i) en_q <= en_wdata_i;
      flag_q <= flag_d;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_q);

  // R3: a newly raised flag needs an event, a hit and its enable one clock earlier
  p_set_needs_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & ~$past(flag_q)) & ~$past(hit_i & en_q & {NCH{evt_i}})) == '0);

  // R4: with all enables clear no flag rises
  p_disabled_no_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

  // R5: without a count step no flag rises
  p_no_step_no_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> ((flag_q & ~$past(flag_q)) == '0));

  // R7: cleared bits with no concurrent set are zero afterwards
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_i |=> ((flag_q & $past(clr_i & ~set_vec)) == '0));

  // R8: the interrupt only rises after a count step or an enable write
  p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(evt_i) || $past(en_wr_i)));

endmodule

// File: rtl/ocu_top.sv
module ocu_top
  import ocu_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int CNT_W  = 16,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o
);

  localparam int CMP_BYTES = 2 * NCH;
  localparam int EN_OFS    = CMP_BYTES;
  localparam int FLAG_OFS  = CMP_BYTES + 1;
  localparam int TOP_BIT   = BUS_W - 1;

  // Channel n-1 (0-based) sits at bit TOP_BIT-(n-1) of the mask/flag bytes
  function automatic logic [BUS_W-1:0] pack_ch(input logic [NCH-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    for (int i = 0; i < NCH; i++) r[TOP_BIT-i] = v[i];
    return r;
  endfunction

  function automatic logic [NCH-1:0] unpack_ch(input logic [BUS_W-1:0] b);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = b[TOP_BIT-i];
    return r;
  endfunction

  function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a);
    reg_sel_t s;
    int       ai;
    ai     = int'(a);
    s.kind = REG_NONE;
    s.ch   = '0;
    if (ai < CMP_BYTES) begin
      s.kind = a[0] ? REG_CMP_LO : REG_CMP_HI;
      s.ch   = ch_idx_t'(ai / 2);
    end else if (ai == EN_OFS) begin
      s.kind = REG_ENABLE;
    end else if (ai == FLAG_OFS) begin
      s.kind = REG_FLAG;
    end
    return s;
  endfunction

  reg_sel_t         sel;
  logic             evt;
  logic [NCH-1:0]   hit;
  logic [NCH-1:0]   en_w;
  logic [NCH-1:0]   flag_w;
  logic [CNT_W-1:0] cmp_w [NCH];

  assign sel = decode(bus_addr_i);

  ocu_change_det #(.CNT_W(CNT_W)) change_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (count_i),
    .evt_o   (evt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_hi;
    logic wr_lo;
    assign wr_hi = bus_wr_i && (sel.kind == REG_CMP_HI) && (sel.ch == ch_idx_t'(g));
    assign wr_lo = bus_wr_i && (sel.kind == REG_CMP_LO) && (sel.ch == ch_idx_t'(g));

    ocu_channel #(.CNT_W(CNT_W), .BUS_W(BUS_W)) chan_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_hi_i (wr_hi),
      .wr_lo_i (wr_lo),
      .wdata_i (bus_wdata_i),
      .count_i (count_i),
      .cmp_o   (cmp_w[g]),
      .hit_o   (hit[g])
    );
  end

  ocu_flags #(.NCH(NCH)) flags_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .hit_i      (hit),
    .en_wr_i    (bus_wr_i && (sel.kind == REG_ENABLE)),
    .en_wdata_i (unpack_ch(bus_wdata_i)),
    .flag_wr_i  (bus_wr_i && (sel.kind == REG_FLAG)),
    .clr_i      (unpack_ch(bus_wdata_i)),
    .en_o       (en_w),
    .flag_o     (flag_w),
    .irq_o      (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (sel.kind)
      REG_ENABLE: bus_rdata_o = pack_ch(en_w);
      REG_FLAG:   bus_rdata_o = pack_ch(flag_w);
      REG_CMP_HI, REG_CMP_LO: begin
        for (int i = 0; i < NCH; i++) begin
          if (sel.ch == ch_idx_t'(i)) begin
            bus_rdata_o = (sel.kind == REG_CMP_HI) ? BUS_W'(cmp_w[i][CNT_W-1:BUS_W])
                                                   : cmp_w[i][BUS_W-1:0];
          end
        end
      end
      default: bus_rdata_o = '0;
    endcase
  end

  // R1: interrupt is low in the first clock after reset
  p_irq_low_after_reset_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !irq_o);

endmodule

// File: tb/ocu_top_tb_top.sv
module ocu_top_tb_top;

  localparam int CLK_P = 10;
  localparam int NCH   = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] count;
  logic [3:0]  addr;
  logic        wr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ocu_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .count_i     (count),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    addr  = 4'(a);
    wdata = 8'(d);
    wr    = 1'b1;
    @(posedge clk); #1;
    wr    = 1'b0;
  endtask

  task automatic rd_reg(input int a, output int d);
    addr = 4'(a);
    #1;
    d = int'(rdata);
  endtask

  task automatic step(input int v);
    count = 16'(v);
    @(posedge clk); #1;
  endtask

  task automatic set_cmp(input int ch, input int v);
    wr_reg(2*ch, (v >> 8) & 8'hFF);
    wr_reg(2*ch + 1, v & 8'hFF);
  endtask

  task automatic check_flags(input string req, input int exp);
    int d;
    rd_reg(11, d);
    check(req, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int d;
    int cv [NCH];
    int expf;
    rst_n = 1'b0; count = '0; addr = '0; wr = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 10; a++) begin rd_reg(a, d); check("R1 cmp byte", d, 8'hFF); end
    rd_reg(10, d); check("R1 enable", d, 0);
    check_flags("R1 flags", 0);
    check("R1 irq", int'(irq), 0);

    // R2 register map and readback
    for (int k = 0; k < NCH; k++) set_cmp(k, ((8'h10 + k) << 8) | (8'h20 + k));
    for (int k = 0; k < NCH; k++) begin
      rd_reg(2*k, d);     check("R2 hi byte", d, 8'h10 + k);
      rd_reg(2*k + 1, d); check("R2 lo byte", d, 8'h20 + k);
    end
    wr_reg(10, 8'hFF); rd_reg(10, d); check("R2 enable unused bits", d, 8'hF8);
    wr_reg(10, 0);
    for (int a = 12; a < 16; a++) begin
      wr_reg(a, 8'h5A); rd_reg(a, d); check("R2 unmapped read", d, 0);
    end
    rd_reg(10, d); check("R2 unmapped write no effect enable", d, 0);
    rd_reg(0, d);  check("R2 unmapped write no effect cmp", d, 8'h10);
    check_flags("R2 unmapped write no effect flags", 0);

    // R3/R9 per-channel position, other matches ignored
    for (int k = 0; k < NCH; k++) begin
      cv[k] = 16'h0100 * (k + 1) + 3 * k + 1;
      set_cmp(k, cv[k]);
    end
    for (int k = 0; k < NCH; k++) begin
      step(0);
      wr_reg(11, 8'hF8);
      wr_reg(10, 8'h80 >> k);
      step(cv[k]);
      check_flags("R3 single channel bit", 8'h80 >> k);
      check("R8 irq on enabled flag", int'(irq), 1);
      for (int j = 0; j < NCH; j++) if (j != k) step(cv[j]);
      check_flags("R4 other channels disabled", 8'h80 >> k);
      wr_reg(11, 8'hF8);
      check_flags("R7 clear all", 0);
      check("R8 irq low after clear", int'(irq), 0);
    end

    // R9 compare written right before the step is used
    step(0); wr_reg(10, 8'h80);
    set_cmp(0, 16'h0777);
    step(16'h0777);
    check_flags("R9 new compare value used", 8'h80);
    wr_reg(11, 8'hF8);

    // R4 all disabled
    wr_reg(10, 0);
    for (int k = 0; k < NCH; k++) begin step(0); step(cv[k]); end
    set_cmp(0, cv[0]);
    check_flags("R4 all disabled", 0);
    check("R4 irq with all disabled", int'(irq), 0);

    // R3 walk: all enabled, count walks over distinct compare values
    for (int k = 0; k < NCH; k++) begin cv[k] = 200 + 4 * k; set_cmp(k, cv[k]); end
    wr_reg(10, 8'hF8);
    expf = 0;
    for (int v = 190; v < 230; v++) begin
      step(v);
      for (int k = 0; k < NCH; k++) if (v == cv[k]) expf |= (1 << (7 - k));
      check_flags("R3 walk", expf);
    end
    wr_reg(11, 8'hF8);

    // R6 and R8: every enable mask with all channels matching together
    for (int m = 0; m < 32; m++) begin
      wr_reg(11, 8'hF8);
      wr_reg(10, m << 3);
      for (int k = 0; k < NCH; k++) set_cmp(k, 16'hA000 + m);
      step(0);
      step(16'hA000 + m);
      check_flags("R6 simultaneous match", m << 3);
      check("R8 irq vs mask", int'(irq), (m != 0) ? 1 : 0);
    end

    // R5 held count sets once
    wr_reg(11, 8'hF8);
    check_flags("R5 cleared while held", 0);
    repeat (3) step(16'hA000 + 31);
    check_flags("R5 held count no re-set", 0);

    // R7 write-one-to-clear, zero no effect, set wins
    step(0); step(16'hA000 + 31);
    check_flags("R7 all set", 8'hF8);
    wr_reg(11, 8'h50);
    check_flags("R7 partial clear", 8'hA8);
    wr_reg(11, 8'h00);
    check_flags("R7 zeros no effect", 8'hA8);
    step(0);
    addr = 4'd11; wdata = 8'hF8; wr = 1'b1; count = 16'hA000 + 31;
    @(posedge clk); #1;
    wr = 1'b0;
    check_flags("R7 set wins over clear", 8'hF8);

    // R8 enable gates the interrupt, flags kept
    wr_reg(10, 0);
    check("R8 irq low when disabled", int'(irq), 0);
    check_flags("R8 flags kept when disabled", 8'hF8);
    wr_reg(10, 8'h08);
    check("R8 irq from channel 5", int'(irq), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule